// File: doc/BRIEF.md
# Heat-Only Oven Integrating Controller

This block holds a resonator die at a set temperature by driving a heater made of equal unit current sources. Each time the temperature converter raises its one-cycle valid strobe, the controller subtracts the measured signed code from a stored setpoint. It adds that difference into a saturating integrator. The top bits of the integrator choose how many heater units are switched on, and the units are always enabled as a contiguous run starting at unit 0.

The loop can only add heat. When the die runs hotter than the setpoint, the integrator falls to zero and stays there. When the die is far colder than the setpoint, it rises to full scale and every unit is enabled.

For bench work, a serial test path can take over the heater code. A count is clocked in bit by bit. A load strobe then copies it into a hold register, and while the override mode input is high that register drives the heater instead of the integrator. The integrator keeps running while the override is active.

Top module: `oven_heat_ctrl`

## Requirements
- R1: After reset the integrator is zero, the setpoint is zero, the shift and hold registers are zero, and all heater enables are low.
- R2: On a cycle with sampleValid high, the integrator becomes its old value plus (setpoint − tempCode), both taken as signed two's-complement values. Without the strobe the integrator keeps its value.
- R3: The integrator never drops below zero: a negative sum clamps to 0. A die hotter than the setpoint therefore drives the heater to all-off and holds it there.
- R4: The integrator never exceeds 2^ACC_W−1: a larger sum clamps there. A die far below the setpoint therefore enables all NUM_UNITS units.
- R5: In loop mode the active unit count is the integrator shifted right by ACC_W−5 bits (its top 5 bits by default), limited to NUM_UNITS (17).
- R6: heatEn bit k is high exactly when k is less than the active count, so enabling unit k implies units 0..k−1 are enabled.
- R7: Each cycle with serEn high shifts serBit into the 5-bit test shift register at its LSB end, so a count is sent MSB first.
- R8: A cycle with ovrLoad high and ovrMode high copies the shift register into the hold register, limited to 17. An ovrLoad while ovrMode is low has no effect.
- R9: While ovrMode is high the hold register sets the active count, and the integrator keeps updating on strobes. When ovrMode falls, the integrator's count is used again.
- R10: A cycle with targetWr high stores targetIn as the setpoint. The new setpoint is used from the following sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking a new temperature code |
| tempCode | input | TEMP_W | Signed measured temperature code |
| targetWr | input | 1 | Setpoint write strobe |
| targetIn | input | TEMP_W | Signed setpoint value to store |
| ovrMode | input | 1 | Selects the hold register as the heater source |
| serEn | input | 1 | Serial shift enable |
| serBit | input | 1 | Serial data bit, MSB first |
| ovrLoad | input | 1 | Copies the shift register into the hold register |
| heatEn | output | NUM_UNITS | Thermometer enables, one per heater unit |

## Verification
The bench drives the integrator into both clamps with the largest-magnitude errors the code width allows. A design that wraps instead of clamping would jump from all-on to nearly off, or from off to all-on. It shifts in counts above 17 to confirm the hold register is limited, and issues a load with override off to confirm that the hold register is left untouched. It toggles the override while samples keep arriving, and writes the setpoint in the same cycle as a sample to confirm the old setpoint applies to that sample. A design that paused the integrator during override, or used the new setpoint too early, would show a heater count different from the reference.

// File: rtl/oven_pkg.sv
package oven_pkg;
  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic accumulate;
    logic shift;
    logic load;
    logic targetWr;
    logic useOvr;
  } ovenStrobes_t;
endpackage

// File: rtl/oven_ctrl.sv
module oven_ctrl
  import oven_pkg::*;
(
  input  logic         sampleValid,
  input  logic         targetWr,
  input  logic         ovrMode,
  input  logic         serEn,
  input  logic         ovrLoad,
  output ovenStrobes_t strb
);
  always_comb begin
    strb.accumulate = sampleValid;
    strb.targetWr   = targetWr;
    strb.shift      = serEn;
    // Loading the hold register is only honoured in override mode.
    strb.load       = ovrLoad & ovrMode;
    strb.useOvr     = ovrMode;
  end
endmodule

// File: rtl/oven_dp.sv
module oven_dp
  import oven_pkg::*;
#(
  parameter int TEMP_W    = 16,
  parameter int ACC_W     = 20,
  parameter int NUM_UNITS = 17
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ovenStrobes_t         strb,
  input  logic [TEMP_W-1:0]    tempCode,
  input  logic [TEMP_W-1:0]    targetIn,
  input  logic                 serBit,
  output logic [NUM_UNITS-1:0] heatEn,
  output logic [ACC_W-1:0]     accOut,
  output logic [TEMP_W-1:0]    targetOut
);
  localparam int CODE_W = $clog2(NUM_UNITS + 1);
  localparam int SHIFT  = ACC_W - CODE_W;
  localparam int SUM_W  = ACC_W + 2;
  localparam logic [CODE_W-1:0] FULL_CNT = CODE_W'(NUM_UNITS);
  localparam logic [ACC_W-1:0]  ACC_MAX  = {ACC_W{1'b1}};

  logic [ACC_W-1:0]  acc;
  logic [TEMP_W-1:0] target;
  logic [CODE_W-1:0] shiftReg;
  logic [CODE_W-1:0] ovrCode;

  logic [TEMP_W:0]   err;
  logic [SUM_W-1:0]  sum;
  logic [ACC_W-1:0]  accNext;
  logic [CODE_W-1:0] topBits;
  logic [CODE_W-1:0] loopCount;
  logic [CODE_W-1:0] selCount;

  // Signed error, then a sign-extended sum with headroom on both ends.
  always_comb begin
    err = {target[TEMP_W-1], target} - {tempCode[TEMP_W-1], tempCode};
    sum = {2'b00, acc} + {{(SUM_W-TEMP_W-1){err[TEMP_W]}}, err};
    if (sum[SUM_W-1])       accNext = '0;
    else if (sum[SUM_W-2])  accNext = ACC_MAX;
    else                    accNext = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      target   <= '0;
      shiftReg <= '0;
      ovrCode  <= '0;
    end else begin
      if (strb.accumulate) acc <= accNext;
      if (strb.targetWr)   target <= targetIn;
      if (strb.load)       ovrCode <= (shiftReg > FULL_CNT) ? FULL_CNT : shiftReg;
      if (strb.shift)      shiftReg <= {shiftReg[CODE_W-2:0], serBit};
    end
  end

  always_comb begin
    topBits   = acc[ACC_W-1:SHIFT];
    loopCount = (topBits > FULL_CNT) ? FULL_CNT : topBits;
    selCount  = strb.useOvr ? ovrCode : loopCount;
  end

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    assign heatEn[k] = (selCount > CODE_W'(k));
  end

  assign accOut    = acc;
  assign targetOut = target;
endmodule

// File: rtl/oven_heat_ctrl.sv
module oven_heat_ctrl
  import oven_pkg::*;
#(
  parameter int TEMP_W    = 16,
  parameter int ACC_W     = 20,
  parameter int NUM_UNITS = 17
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleValid,
  input  logic [TEMP_W-1:0]    tempCode,
  input  logic                 targetWr,
  input  logic [TEMP_W-1:0]    targetIn,
  input  logic                 ovrMode,
  input  logic                 serEn,
  input  logic                 serBit,
  input  logic                 ovrLoad,
  output logic [NUM_UNITS-1:0] heatEn
);
  ovenStrobes_t      strb;
  logic [ACC_W-1:0]  accVal;
  logic [TEMP_W-1:0] targetVal;

  oven_ctrl u_ctrl (
    .sampleValid(sampleValid),
    .targetWr   (targetWr),
    .ovrMode    (ovrMode),
    .serEn      (serEn),
    .ovrLoad    (ovrLoad),
    .strb       (strb)
  );

  oven_dp #(.TEMP_W(TEMP_W), .ACC_W(ACC_W), .NUM_UNITS(NUM_UNITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .tempCode (tempCode),
    .targetIn (targetIn),
    .serBit   (serBit),
    .heatEn   (heatEn),
    .accOut   (accVal),
    .targetOut(targetVal)
  );
endmodule

// File: rtl/oven_heat_ctrl_chk.sv
module oven_heat_ctrl_chk #(
  parameter int TEMP_W    = 16,
  parameter int ACC_W     = 20,
  parameter int NUM_UNITS = 17
)(
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleValid,
  input logic                 ovrMode,
  input logic [TEMP_W-1:0]    tempCode,
  input logic [TEMP_W-1:0]    targetVal,
  input logic [ACC_W-1:0]     accVal,
  input logic [NUM_UNITS-1:0] heatEn
);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  p_therm_shape_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((heatEn & (heatEn + 1'b1)) == '0));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (heatEn == '0 && accVal == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !ovrMode) |=> (ovrMode || $stable(heatEn)));

  p_hot_no_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !ovrMode && ($signed(tempCode) > $signed(targetVal)))
      |=> (ovrMode || ($countones(heatEn) <= $countones($past(heatEn)))));

  p_full_scale_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ovrMode && accVal == ACC_MAX) |-> (&heatEn));
endmodule

bind oven_heat_ctrl oven_heat_ctrl_chk #(
  .TEMP_W(TEMP_W), .ACC_W(ACC_W), .NUM_UNITS(NUM_UNITS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .ovrMode    (ovrMode),
  .tempCode   (tempCode),
  .targetVal  (targetVal),
  .accVal     (accVal),
  .heatEn     (heatEn)
);

// File: tb/oven_heat_ctrl_tb.sv
module oven_heat_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 17;
  localparam int AW = 20;
  localparam int ACC_MAXI = (1 << AW) - 1;

  logic clk = 0;
  logic rstN = 0;
  logic sampleValid = 0;
  logic [15:0] tempCode = '0;
  logic targetWr = 0;
  logic [15:0] targetIn = '0;
  logic ovrMode = 0;
  logic serEn = 0;
  logic serBit = 0;
  logic ovrLoad = 0;
  wire  [NU-1:0] heatEn;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  // Behavioural reference state
  int mAcc = 0, mTarget = 0, mSreg = 0, mOvr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oven_heat_ctrl u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .tempCode(tempCode),
    .targetWr(targetWr), .targetIn(targetIn), .ovrMode(ovrMode),
    .serEn(serEn), .serBit(serBit), .ovrLoad(ovrLoad), .heatEn(heatEn)
  );

  function automatic logic [NU-1:0] thermOf(int n);
    logic [NU-1:0] v = '0;
    for (int k = 0; k < NU; k++) if (k < n) v[k] = 1'b1;
    return v;
  endfunction

  function automatic int expCount();
    int c;
    if (ovrMode) return mOvr;
    c = mAcc >> (AW - 5);
    return (c > NU) ? NU : c;
  endfunction

  task automatic chk(string req, logic [NU-1:0] act, logic [NU-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s heatEn=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rstN) begin
      mAcc = 0; mTarget = 0; mSreg = 0; mOvr = 0;
    end else begin
      if (sampleValid) begin
        mAcc = mAcc + mTarget - int'($signed(tempCode));
        if (mAcc < 0) mAcc = 0;
        if (mAcc > ACC_MAXI) mAcc = ACC_MAXI;
      end
      if (ovrMode && ovrLoad) mOvr = (mSreg > NU) ? NU : mSreg;
      if (serEn) mSreg = ((mSreg * 2) + int'(serBit)) % 32;
      if (targetWr) mTarget = int'($signed(targetIn));
    end
    #2;
    chk(curReq, heatEn, thermOf(expCount()));
  endtask

  task automatic sample(int t, int n);
    tempCode = 16'(t);
    for (int i = 0; i < n; i++) begin
      sampleValid = 1; tick();
      sampleValid = 0; tick();
    end
  endtask

  task automatic setTarget(int t);
    targetIn = 16'(t); targetWr = 1; tick(); targetWr = 0;
  endtask

  task automatic shiftIn(int v);
    for (int i = 4; i >= 0; i--) begin
      serEn = 1; serBit = v[i]; tick();
    end
    serEn = 0; serBit = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (3) tick();
    rstN = 1;
    tick();
    chk("R1", heatEn, '0);

    // R10: setpoint write, then R2: accumulation of error
    curReq = "R10";
    setTarget(1000);
    curReq = "R2";
    sample(0, 40);          // +1000 per sample -> 40000, count 1
    chk("R2", heatEn, thermOf(expCount()));
    repeat (5) tick();      // no strobe: hold
    chk("R2", heatEn, thermOf(1));

    // R5: count mapping under a ramp
    curReq = "R5";
    setTarget(20000);
    sample(0, 10);          // +20000 each
    chk("R5", heatEn, thermOf(expCount()));

    // R4: drive to full scale with the largest error
    curReq = "R4";
    setTarget(32767);
    sample(-32768, 20);
    chk("R4", heatEn, {NU{1'b1}});

    // R10: setpoint written in the same cycle as a sample uses the old value
    curReq = "R10";
    targetIn = 16'(-32768); targetWr = 1; tempCode = 16'(0); sampleValid = 1;
    tick();
    targetWr = 0; sampleValid = 0;
    tick();
    chk("R10", heatEn, thermOf(expCount()));

    // R3: hot die drains integrator to zero and it stays there
    curReq = "R3";
    setTarget(0);
    sample(32767, 40);
    chk("R3", heatEn, '0);
    sample(32767, 5);
    chk("R3", heatEn, '0);

    // R6: intermediate codes keep the thermometer shape
    curReq = "R6";
    setTarget(30000);
    for (int i = 0; i < 12; i++) begin
      sample(0, 1);
      chk("R6", heatEn, thermOf(expCount()));
    end

    // R7 / R8: serial load of an oversize value, clamped to 17
    curReq = "R7";
    ovrMode = 1;
    shiftIn(22);
    curReq = "R8";
    ovrLoad = 1; tick(); ovrLoad = 0;
    tick();
    chk("R8", heatEn, thermOf(NU));

    // R7: MSB-first load of 9
    curReq = "R7";
    shiftIn(9);
    ovrLoad = 1; tick(); ovrLoad = 0;
    tick();
    chk("R7", heatEn, thermOf(9));

    // R8: load while override is off is ignored
    curReq = "R8";
    ovrMode = 0;
    shiftIn(3);
    ovrLoad = 1; tick(); ovrLoad = 0;
    ovrMode = 1; tick();
    chk("R8", heatEn, thermOf(9));

    // R9: integrator runs during override, loop resumes afterwards
    curReq = "R9";
    setTarget(32767);
    sample(-32768, 20);
    chk("R9", heatEn, thermOf(9));
    ovrMode = 0; tick();
    chk("R9", heatEn, {NU{1'b1}});

    // R1: reset in mid operation clears everything
    curReq = "R1";
    rstN = 0; tick(); tick();
    rstN = 1; tick();
    chk("R1", heatEn, '0);
    ovrMode = 1; tick();
    chk("R1", heatEn, '0);
    ovrMode = 0; tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule